// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block lets a small processor core run byte-wide read and write cycles on an external memory or I/O bus with a 16-bit address. The upper address byte has its own output pins. The lower address byte shares an 8-bit bus with the data and is announced by an active-low address strobe, so an external latch can capture it. An active-low data strobe marks the data window, a read/write line gives the direction, and an output-enable tells the pad ring when the block drives the shared bus.

The core starts a cycle with a request and receives a one-cycle completion pulse. A read returns its data with that pulse. Every cycle runs through these states in order: address, address hold, data setup, strobe, then end. An extended-timing input, captured when the request is accepted, lengthens the strobe by a fixed number of clocks. An active-low wait input passes through a two-flop synchroniser and stretches the strobe one clock at a time.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is held, and after it, with no request: as_n=1, ds_n=1, ad_oe=0, done=0 and rw=1.
- R2: The upper byte addr[15:8] appears on a_hi from the address cycle until done. as_n is low for exactly one clock, which is the first clock after acceptance. ad_o carries addr[7:0] with ad_oe=1 in that clock and in the clock that follows it. as_n and ds_n are never low together.
- R3: On a read (we=0), ad_oe is 0 from the third cycle through the done cycle, so the bus floats for one clock before ds_n falls. rdata shows the ad_i value sampled at the last low-strobe clock edge, and is valid while done is high.
- R4: On a write (we=1), ad_o carries wdata with ad_oe=1 from the third cycle through the done cycle. The data is therefore present one clock before ds_n falls and one clock after ds_n rises.
- R5: rw equals the inverse of we (1=read, 0=write) from the address cycle through the done cycle, and is 1 when idle.
- R6: With no wait and no extension, done comes in the 5th clock after acceptance, and ds_n is low for exactly 1 clock.
- R7: wait_n passes through 2 flip-flops and is sampled at the last strobe clock, and again at each wait clock. Let k be the number of clock edges, starting at the acceptance edge, at which wait_n is held low. Then k-2-E wait clocks are added (never fewer than 0), where E is the extension length.
- R8: When ext_en=1 at acceptance, the strobe and the whole cycle each gain exactly E=2 clocks.
- R9: done is high for one clock per accepted request, in the clock where ds_n has just risen. The cycle length is 5+E+W clocks, where W is the number of wait clocks.
- R10: A req raised while a cycle is in progress is ignored. No second address strobe occurs and no second done is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Core request, accepted only when idle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Cycle address |
| wdata | input | 8 | Write data |
| ext_en | input | 1 | Extended timing for this cycle |
| rdata | output | 8 | Read data, valid with done |
| done | output | 1 | One-clock completion pulse |
| wait_n | input | 1 | Asynchronous active-low wait request |
| a_hi | output | 8 | Upper address byte pins |
| ad_o | output | 8 | Shared bus output value |
| ad_oe | output | 1 | Shared bus drive enable (0 = high impedance) |
| ad_i | input | 8 | Shared bus input value |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| rw | output | 1 | 1 = read, 0 = write |

## Verification
A sequencer that is stuck or skips a state shows up in the same cycle as a wrong strobe count: two address strobes, or a data strobe that is too short or too long. A stuck sequencer also shows up as a done pulse that comes at a clock other than 5+E+W. A synchroniser with the wrong depth, or a wait sampled at the wrong moment, shifts the done pulse by exactly one clock per error. A wrong drive enable or a wrong data multiplex becomes visible on the shared bus within one clock of the address hold, and a wrong read capture shows on rdata in the done cycle.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_HOLD  = 3'd2,
    ST_SETUP = 3'd3,
    ST_STRB  = 3'd4,
    ST_WAIT  = 3'd5,
    ST_END   = 3'd6
  } xbus_state_t;

  // Extra strobe clocks for one cycle, given the latched extension flag.
  function automatic int unsigned ext_clocks(input logic ext, input int unsigned n);
    return ext ? n : 0;
  endfunction

  // True in states where the data strobe is asserted.
  function automatic logic strobe_on(input xbus_state_t s);
    return (s == ST_STRB) || (s == ST_WAIT);
  endfunction

  // True in states where the low address byte is on the shared bus.
  function automatic logic addr_phase(input xbus_state_t s);
    return (s == ST_ADDR) || (s == ST_HOLD);
  endfunction

endpackage

// File: rtl/xbus_wait_sync.sv
module xbus_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_n,
  output logic wait_act
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= wait_n;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign wait_act = ~chain[STAGES-1];
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int EXT_CLKS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        ext_en,
  input  logic        wait_act,
  output xbus_state_t state,
  output logic        accept,
  output logic        strobe_end
);
  localparam int CW = $clog2(EXT_CLKS + 1);

  xbus_state_t nxt;
  logic [CW-1:0] ext_cnt;
  logic ext_q;
  logic cnt_zero;

  assign cnt_zero   = (ext_cnt == '0);
  assign accept     = (state == ST_IDLE) && req;
  assign strobe_end = ((state == ST_STRB) && cnt_zero && !wait_act) ||
                      ((state == ST_WAIT) && !wait_act);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (req) nxt = ST_ADDR;
      ST_ADDR:  nxt = ST_HOLD;
      ST_HOLD:  nxt = ST_SETUP;
      ST_SETUP: nxt = ST_STRB;
      ST_STRB:  if (cnt_zero) nxt = wait_act ? ST_WAIT : ST_END;
      ST_WAIT:  if (!wait_act) nxt = ST_END;
      ST_END:   nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      ext_q   <= 1'b0;
      ext_cnt <= '0;
    end else begin
      state <= nxt;
      if (accept) ext_q <= ext_en;
      if (state == ST_SETUP)
        ext_cnt <= CW'(ext_clocks(ext_q, EXT_CLKS));
      else if (state == ST_STRB && !cnt_zero)
        ext_cnt <= ext_cnt - 1'b1;
    end
  end

  // R7: a wait clock repeats while the synchronised wait stays asserted
  p_wait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && wait_act) |=> (state == ST_WAIT));

  // R6: the end state is only ever entered from a completed strobe
  p_end_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_END) |-> $past(strobe_end));

  // R10: a cycle starts only from idle
  p_start_from_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR) |-> ($past(state) == ST_IDLE));
endmodule

// File: rtl/xbus_datapath.sv
module xbus_datapath
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  xbus_state_t          state,
  input  logic                 accept,
  input  logic                 strobe_end,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [DATA_W-1:0]    ad_i,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic [DATA_W-1:0]    ad_o,
  output logic                 ad_oe,
  output logic                 as_n,
  output logic                 ds_n,
  output logic                 rw,
  output logic [DATA_W-1:0]    rdata,
  output logic                 done
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              we_q;
  logic              busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      rdata   <= '0;
    end else begin
      if (accept) begin
        addr_q  <= addr;
        wdata_q <= wdata;
        we_q    <= we;
      end
      if (strobe_end && !we_q) rdata <= ad_i;
    end
  end

  assign busy = (state != ST_IDLE);
  assign a_hi = addr_q[ADDR_W-1:DATA_W];
  assign as_n = ~(state == ST_ADDR);
  assign ds_n = ~strobe_on(state);
  assign rw   = busy ? ~we_q : 1'b1;
  assign done = (state == ST_END);

  always_comb begin
    if (addr_phase(state)) begin
      ad_oe = 1'b1;
      ad_o  = addr_q[DATA_W-1:0];
    end else if (busy && we_q) begin
      ad_oe = 1'b1;
      ad_o  = wdata_q;
    end else begin
      ad_oe = 1'b0;
      ad_o  = '0;
    end
  end

  // R2: address strobe is a single-clock pulse
  p_as_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !as_n |=> as_n);

  // R2: the two strobes never overlap
  p_strobes_apart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!as_n && !ds_n));

  // R2: address is still driven in the clock after the strobe rises
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(as_n) |-> ad_oe);

  // R3: on a read the bus is already released the clock before ds_n falls
  p_float_before_ds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ds_n) && rw) |-> (!ad_oe && !$past(ad_oe)));

  // R4: write data is still driven when ds_n rises
  p_wdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ds_n) && !rw) |-> ad_oe);

  // R5: direction is unchanged across the rising data strobe
  p_rw_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ds_n) |-> $stable(rw));

  // R9: done is a single-clock pulse, aligned with the strobe release
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_at_ds_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(ds_n));
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int EXT_CLKS    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic                      ext_en,
  output logic [DATA_W-1:0]         rdata,
  output logic                      done,
  input  logic                      wait_n,
  output logic [ADDR_W-DATA_W-1:0]  a_hi,
  output logic [DATA_W-1:0]         ad_o,
  output logic                      ad_oe,
  input  logic [DATA_W-1:0]         ad_i,
  output logic                      as_n,
  output logic                      ds_n,
  output logic                      rw
);
  xbus_state_t state;
  logic accept;
  logic strobe_end;
  logic wait_act;

  xbus_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .wait_n(wait_n), .wait_act(wait_act)
  );

  xbus_seq #(.EXT_CLKS(EXT_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .ext_en(ext_en),
    .wait_act(wait_act), .state(state), .accept(accept),
    .strobe_end(strobe_end)
  );

  xbus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .state(state), .accept(accept),
    .strobe_end(strobe_end), .we(we), .addr(addr), .wdata(wdata),
    .ad_i(ad_i), .a_hi(a_hi), .ad_o(ad_o), .ad_oe(ad_oe), .as_n(as_n),
    .ds_n(ds_n), .rw(rw), .rdata(rdata), .done(done)
  );
endmodule

// File: tb/sim_xbus_ctrl.sv
`timescale 1ns/1ps
module sim_xbus_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, ext_en = 1'b0, wait_n = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata, ad_o, ad_i, a_hi;
  logic done, ad_oe, as_n, ds_n, rw;
  logic [15:0] lat_a = '0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  xbus_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ext_en(ext_en), .rdata(rdata), .done(done), .wait_n(wait_n), .a_hi(a_hi),
    .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i), .as_n(as_n), .ds_n(ds_n), .rw(rw)
  );

  function automatic logic [7:0] dev_pat(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  // external device: latch low byte on the address strobe, answer reads
  always @(negedge clk) if (!as_n) lat_a <= {a_hi, ad_o};
  assign ad_i = ad_oe ? ad_o : dev_pat(lat_a);

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic run_txn(input bit w, input logic [15:0] a, input logic [7:0] d,
                         input bit x, input int k, input bit poke);
    int wl, as_cnt, ds_cnt, done_cnt, done_at, exp_w, exp_len, ext_n;
    bit hi_ok, lo_ok, bus_ok, rw_ok, as_first, ds_hi_at_done;
    logic [7:0] rd;
    ext_n = x ? 2 : 0;
    exp_w = k - 2 - ext_n;
    if (exp_w < 0) exp_w = 0;
    exp_len = 5 + ext_n + exp_w;
    as_cnt = 0; ds_cnt = 0; done_cnt = 0; done_at = -1;
    hi_ok = 1; lo_ok = 1; bus_ok = 1; rw_ok = 1; as_first = 0;
    ds_hi_at_done = 0; rd = '0;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; ext_en = x; wl = k;
    wait_n = (wl > 0) ? 1'b0 : 1'b1;
    if (wl > 0) wl--;
    for (int n = 1; n <= 80; n++) begin
      @(negedge clk);
      req = (poke && n == 2);
      if (poke && n == 2) addr = ~a;
      wait_n = (wl > 0) ? 1'b0 : 1'b1;
      if (wl > 0) wl--;
      if (!as_n) as_cnt++;
      if (!ds_n) ds_cnt++;
      if (n == 1 && !as_n) as_first = 1;
      if (done) begin
        done_cnt++;
        if (done_at < 0) begin
          done_at = n; rd = rdata; ds_hi_at_done = ds_n;
        end
      end
      if (done_at < 0 || done_at == n) begin
        if (a_hi !== a[15:8]) hi_ok = 0;
        if (rw !== !w) rw_ok = 0;
        if (n <= 2) begin
          if (!(ad_oe === 1'b1 && ad_o === a[7:0])) lo_ok = 0;
        end else if (w) begin
          if (!(ad_oe === 1'b1 && ad_o === d)) bus_ok = 0;
        end else begin
          if (ad_oe !== 1'b0) bus_ok = 0;
        end
      end
      if (done_at > 0 && n >= done_at + 3) break;
    end
    chk(as_first && as_cnt == 1, "R2 single address strobe", as_cnt, 1);
    chk(hi_ok, "R2 upper address pins", a_hi, a[15:8]);
    chk(lo_ok, "R2 low address on shared bus", ad_o, a[7:0]);
    chk(rw_ok, "R5 direction line", rw, !w);
    if (w) chk(bus_ok, "R4 write data window", ad_o, d);
    else begin
      chk(bus_ok, "R3 bus released on read", ad_oe, 0);
      chk(rd === dev_pat(a), "R3 read data", rd, dev_pat(a));
    end
    chk(ds_cnt == 1 + ext_n + exp_w, (k > 0) ? "R7 strobe length with wait"
        : (x ? "R8 strobe length extended" : "R6 strobe length"), ds_cnt, 1 + ext_n + exp_w);
    chk(done_at == exp_len, "R9 cycle length", done_at, exp_len);
    chk(done_cnt == 1 && ds_hi_at_done, poke ? "R10 busy request ignored" : "R9 single done",
        done_cnt, 1);
  endtask

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] ra;
    logic [7:0] rdv;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(as_n === 1'b1 && ds_n === 1'b1, "R1 strobes in reset", {as_n, ds_n}, 3);
    chk(ad_oe === 1'b0 && done === 1'b0 && rw === 1'b1, "R1 bus idle in reset",
        {ad_oe, done, rw}, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(as_n === 1'b1 && ds_n === 1'b1 && ad_oe === 1'b0 && done === 1'b0,
        "R1 idle after reset", {as_n, ds_n, ad_oe, done}, 4'b1100);
    // directed corners
    run_txn(1'b0, 16'h0000, 8'h00, 1'b0, 0, 1'b0);   // R6 base read
    run_txn(1'b1, 16'hFFFF, 8'h5C, 1'b0, 0, 1'b0);   // R4 base write
    run_txn(1'b0, 16'h1234, 8'h00, 1'b1, 0, 1'b0);   // R8 extended read
    run_txn(1'b1, 16'h8001, 8'hE7, 1'b1, 0, 1'b0);   // R8 extended write
    run_txn(1'b0, 16'hA55A, 8'h00, 1'b0, 2, 1'b0);   // R7 wait too short to count
    run_txn(1'b0, 16'h00FF, 8'h00, 1'b0, 3, 1'b0);   // R7 one wait clock
    run_txn(1'b1, 16'h7F80, 8'h81, 1'b0, 6, 1'b0);   // R7 four wait clocks
    run_txn(1'b0, 16'hC3C3, 8'h00, 1'b1, 4, 1'b0);   // R7 wait absorbed by extension
    run_txn(1'b1, 16'h3C3C, 8'h18, 1'b1, 7, 1'b0);   // R7 wait after extension
    run_txn(1'b0, 16'h4242, 8'h00, 1'b0, 0, 1'b1);   // R10 request while busy
    // constrained random
    for (int i = 0; i < 40; i++) begin
      ra  = 16'($urandom);
      rdv = 8'($urandom);
      run_txn(1'($urandom), ra, rdv, 1'($urandom), int'($urandom % 8),
              ($urandom % 4) == 0);
    end
    repeat (2) @(negedge clk);
    chk(rw === 1'b1 && ad_oe === 1'b0, "R5 idle direction", rw, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule